// File: doc/BRIEF.md
# Eight-State Trellis Add-Compare-Select Step

This unit advances the state metrics of an eight-state recursive systematic convolutional code by one trellis stage. Each accepted step supplies a systematic channel LLR, an a priori LLR, a parity channel LLR and the eight metrics of the previous stage. The unit returns the eight metrics of the next stage one cycle later. A direction input selects a forward recursion, which uses predecessor connections, or a backward recursion, which uses successor connections. A second input selects how the two paths into each state are merged. In exact mode the larger candidate is taken and a small logarithmic correction is added. In max-only mode the larger candidate is taken alone.

The unit is intended to sit inside a soft-output decoder. That decoder streams stages through the unit, feeds each result back as the next input and stores the results elsewhere. The start input seeds a recursion with a fixed initial vector. Each output vector is normalised so that state 0 reads zero, which keeps the metrics inside a fixed width. The input and output handshakes are valid/ready, and one step can be accepted every cycle.

Top module: `trellis_acs_step`

## Requirements
- R1: With dir_bwd = 0, each state s merges two candidates. Each candidate is the input metric of a predecessor plus the branch metric of that path. The predecessors are given as (bit-0 state, parity; bit-1 state, parity) for s = 0..7: 0:(0,0;1,1) 1:(3,1;2,0) 2:(4,1;5,0) 3:(7,0;6,1) 4:(1,0;0,1) 5:(2,1;3,0) 6:(5,1;4,0) 7:(6,0;7,1).
- R2: With dir_bwd = 1, the same merge uses successor connections, given in the same form: 0:(0,0;4,1) 1:(4,0;0,1) 2:(5,1;1,0) 3:(1,1;5,0) 4:(2,1;6,0) 5:(6,1;2,0) 6:(7,0;3,1) 7:(3,0;7,1).
- R3: The branch metric of a path with information bit u and parity bit p is (llr_sys + llr_apr)·u + llr_par·p. All LLRs are two's-complement signed values.
- R4: With exact_en = 1, the merge result is max(a,b) + c(|a−b|), where c is 3 for a difference of 0, 2 for 1..3, 1 for 4..8 and 0 for 9 or more. These values are the log correction in units of one quarter.
- R5: With exact_en = 0, the merge result is max(a,b) with no correction.
- R6: Each output field equals the merged metric of that state minus the merged metric of state 0, saturated to the signed MW-bit range. State s occupies bits [s·MW +: MW], so field 0 is always zero.
- R7: When start = 1 on an accepted step, in_metrics is ignored. The step instead uses 0 for state 0 and −2^(MW−2) for every other state.
- R8: An accepted step (in_valid and in_ready) appears on out_valid/out_metrics in the next cycle. in_ready equals (not out_valid) or out_ready, so a new step can be taken every cycle. With no accept and the output consumed, out_valid drops.
- R9: While out_valid = 1 and out_ready = 0, out_valid and out_metrics hold their values.
- R10: After synchronous reset, out_valid = 0 and in_ready = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Step request valid |
| in_ready | output | 1 | Unit can take a step this cycle |
| start | input | 1 | Use the initial metric vector instead of in_metrics |
| dir_bwd | input | 1 | 0 = forward (predecessors), 1 = backward (successors) |
| exact_en | input | 1 | 1 = corrected merge, 0 = max-only merge |
| llr_sys | input | LW | Systematic channel LLR, signed |
| llr_apr | input | LW | A priori LLR, signed |
| llr_par | input | LW | Parity channel LLR, signed |
| in_metrics | input | 8·MW | Previous-stage metrics, state s at [s·MW +: MW] |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_metrics | output | 8·MW | Normalised next-stage metrics |

## Verification
The two functions that collide most often are taking a new step and holding a result that is still waiting. A new step can arrive in the same cycle that the pending result is drained. When out_ready is low, in_ready must fall so that the waiting vector is not overwritten. The bench provokes this by toggling in_valid and out_ready independently every cycle across all direction, merge and start combinations. It judges the outcome against a queue-based reference model. Each cycle it compares out_valid, in_ready and the delivered vector with the model, and it checks that a stalled vector stays unchanged until it is taken. Start steps with arbitrary in_metrics are mixed into the same traffic. This shows that the seed vector replaces the inputs even when a step is accepted back-to-back with a drain.

// File: rtl/tacs_pkg.sv
package tacs_pkg;

    localparam int NS = 8;

    typedef struct packed {
        logic       par;
        logic [2:0] st;
    } link_t;

    // Trellis connection of state s for information bit u.
    // Forward gives the predecessor; backward gives the successor.
    function automatic link_t trellis_link(input logic bwd, input logic u, input logic [2:0] s);
        link_t r;
        case ({bwd, u, s})
            5'b00_000: r = '{1'b0, 3'd0};
            5'b00_001: r = '{1'b1, 3'd3};
            5'b00_010: r = '{1'b1, 3'd4};
            5'b00_011: r = '{1'b0, 3'd7};
            5'b00_100: r = '{1'b0, 3'd1};
            5'b00_101: r = '{1'b1, 3'd2};
            5'b00_110: r = '{1'b1, 3'd5};
            5'b00_111: r = '{1'b0, 3'd6};
            5'b01_000: r = '{1'b1, 3'd1};
            5'b01_001: r = '{1'b0, 3'd2};
            5'b01_010: r = '{1'b0, 3'd5};
            5'b01_011: r = '{1'b1, 3'd6};
            5'b01_100: r = '{1'b1, 3'd0};
            5'b01_101: r = '{1'b0, 3'd3};
            5'b01_110: r = '{1'b0, 3'd4};
            5'b01_111: r = '{1'b1, 3'd7};
            5'b10_000: r = '{1'b0, 3'd0};
            5'b10_001: r = '{1'b0, 3'd4};
            5'b10_010: r = '{1'b1, 3'd5};
            5'b10_011: r = '{1'b1, 3'd1};
            5'b10_100: r = '{1'b1, 3'd2};
            5'b10_101: r = '{1'b1, 3'd6};
            5'b10_110: r = '{1'b0, 3'd7};
            5'b10_111: r = '{1'b0, 3'd3};
            5'b11_000: r = '{1'b1, 3'd4};
            5'b11_001: r = '{1'b1, 3'd0};
            5'b11_010: r = '{1'b0, 3'd1};
            5'b11_011: r = '{1'b0, 3'd5};
            5'b11_100: r = '{1'b0, 3'd6};
            5'b11_101: r = '{1'b0, 3'd2};
            5'b11_110: r = '{1'b1, 3'd3};
            default:   r = '{1'b1, 3'd7};
        endcase
        return r;
    endfunction

    // ln(1+exp(-d)) in quarter units, d in quarter units, saturated at 15.
    function automatic logic [1:0] corr_lut(input logic [3:0] d);
        logic [1:0] c;
        if (d == 4'd0)      c = 2'd3;
        else if (d <= 4'd3) c = 2'd2;
        else if (d <= 4'd8) c = 2'd1;
        else                c = 2'd0;
        return c;
    endfunction

endpackage

// File: rtl/tacs_branch.sv
module tacs_branch #(
    parameter int LW = 8,
    parameter int GW = LW + 2
) (
    input  logic signed [LW-1:0] llr_sys,
    input  logic signed [LW-1:0] llr_apr,
    input  logic signed [LW-1:0] llr_par,
    output logic signed [GW-1:0] gam [4]
);
    logic signed [GW-1:0] sys_x, apr_x, par_x, info_w;

    always_comb begin
        sys_x  = {{(GW-LW){llr_sys[LW-1]}}, llr_sys};
        apr_x  = {{(GW-LW){llr_apr[LW-1]}}, llr_apr};
        par_x  = {{(GW-LW){llr_par[LW-1]}}, llr_par};
        info_w = sys_x + apr_x;
        // index {u, p}
        gam[0] = '0;
        gam[1] = par_x;
        gam[2] = info_w;
        gam[3] = info_w + par_x;
    end
endmodule

// File: rtl/tacs_acs.sv
module tacs_acs
    import tacs_pkg::*;
#(
    parameter int MW = 12,
    parameter int GW = 10,
    parameter int IW = MW + 4
) (
    input  logic signed [MW-1:0] m0,
    input  logic signed [MW-1:0] m1,
    input  logic signed [GW-1:0] g0,
    input  logic signed [GW-1:0] g1,
    input  logic                 exact_en,
    output logic signed [IW-1:0] merged
);
    logic signed [IW-1:0] c0, c1, best;
    logic signed [IW:0]   diff;
    logic        [IW:0]   mag;
    logic        [3:0]    idx;
    logic        [1:0]    corr;

    always_comb begin
        c0   = {{(IW-MW){m0[MW-1]}}, m0} + {{(IW-GW){g0[GW-1]}}, g0};
        c1   = {{(IW-MW){m1[MW-1]}}, m1} + {{(IW-GW){g1[GW-1]}}, g1};
        diff = {c0[IW-1], c0} - {c1[IW-1], c1};
        mag  = diff[IW] ? (~diff + 1'b1) : diff;
        idx  = (|mag[IW:4]) ? 4'hF : mag[3:0];
        corr = exact_en ? corr_lut(idx) : 2'd0;
        best = diff[IW] ? c1 : c0;
        merged = best + {{(IW-2){1'b0}}, corr};
    end
endmodule

// File: rtl/tacs_norm.sv
module tacs_norm #(
    parameter int NS = 8,
    parameter int MW = 12,
    parameter int IW = MW + 4
) (
    input  logic signed [IW-1:0] raw [NS],
    output logic [NS*MW-1:0]     normed
);
    localparam logic signed [IW:0] HI = (IW+1)'((2 ** (MW-1)) - 1);
    localparam logic signed [IW:0] LO = -((IW+1)'(2 ** (MW-1)));

    logic signed [IW:0] rel [NS];

    always_comb begin
        for (int s = 0; s < NS; s++) begin
            rel[s] = {raw[s][IW-1], raw[s]} - {raw[0][IW-1], raw[0]};
            if (rel[s] > HI)      normed[s*MW +: MW] = HI[MW-1:0];
            else if (rel[s] < LO) normed[s*MW +: MW] = LO[MW-1:0];
            else                  normed[s*MW +: MW] = rel[s][MW-1:0];
        end
    end
endmodule

// File: rtl/trellis_acs_step.sv
module trellis_acs_step
    import tacs_pkg::*;
#(
    parameter int MW = 12,
    parameter int LW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               start,
    input  logic               dir_bwd,
    input  logic               exact_en,
    input  logic [LW-1:0]      llr_sys,
    input  logic [LW-1:0]      llr_apr,
    input  logic [LW-1:0]      llr_par,
    input  logic [NS*MW-1:0]   in_metrics,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [NS*MW-1:0]   out_metrics
);
    localparam int GW = LW + 2;
    localparam int IW = MW + 4;
    localparam logic signed [MW-1:0] INIT_NEG = -(MW'(2 ** (MW-2)));

    logic signed [GW-1:0] gam [4];
    logic signed [MW-1:0] src [NS];
    logic signed [IW-1:0] merged [NS];
    logic [NS*MW-1:0]     normed;
    logic                 accept;

    tacs_branch #(.LW(LW), .GW(GW)) i_branch (
        .llr_sys (llr_sys),
        .llr_apr (llr_apr),
        .llr_par (llr_par),
        .gam     (gam)
    );

    always_comb begin
        for (int s = 0; s < NS; s++) begin
            if (start) src[s] = (s == 0) ? '0 : INIT_NEG;
            else       src[s] = in_metrics[s*MW +: MW];
        end
    end

    for (genvar s = 0; s < NS; s++) begin : g_state
        localparam link_t F0 = trellis_link(1'b0, 1'b0, 3'(s));
        localparam link_t F1 = trellis_link(1'b0, 1'b1, 3'(s));
        localparam link_t B0 = trellis_link(1'b1, 1'b0, 3'(s));
        localparam link_t B1 = trellis_link(1'b1, 1'b1, 3'(s));

        logic signed [MW-1:0] m0, m1;
        logic signed [GW-1:0] g0, g1;

        always_comb begin
            m0 = dir_bwd ? src[B0.st] : src[F0.st];
            m1 = dir_bwd ? src[B1.st] : src[F1.st];
            g0 = gam[{1'b0, dir_bwd ? B0.par : F0.par}];
            g1 = gam[{1'b1, dir_bwd ? B1.par : F1.par}];
        end

        tacs_acs #(.MW(MW), .GW(GW), .IW(IW)) i_acs (
            .m0       (m0),
            .m1       (m1),
            .g0       (g0),
            .g1       (g1),
            .exact_en (exact_en),
            .merged   (merged[s])
        );
    end

    tacs_norm #(.NS(NS), .MW(MW), .IW(IW)) i_norm (
        .raw    (merged),
        .normed (normed)
    );

    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_metrics <= '0;
        end else begin
            if (in_ready) out_valid <= in_valid;
            if (accept)   out_metrics <= normed;
        end
    end
endmodule

// File: rtl/tacs_chk.sv
module tacs_chk #(
    parameter int MW = 12,
    parameter int NS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [NS*MW-1:0] out_metrics
);
    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    p_drain_r8: assert property (@(posedge clk) disable iff (rst)
        (!(in_valid && in_ready) && !(out_valid && !out_ready)) |=> !out_valid);

    p_block_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_metrics)));

    p_reset_r10: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && in_ready));
endmodule

bind trellis_acs_step tacs_chk #(.MW(MW), .NS(tacs_pkg::NS)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_metrics (out_metrics)
);

// File: tb/test_trellis_acs_step.sv
`timescale 1ns/1ps
module test_trellis_acs_step;
    localparam int MW = 12;
    localparam int LW = 8;
    localparam int NS = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, start = 1'b0, dir_bwd = 1'b0, exact_en = 1'b0, out_ready = 1'b1;
    logic [LW-1:0] llr_sys = '0, llr_apr = '0, llr_par = '0;
    logic [NS*MW-1:0] in_metrics = '0;
    logic in_ready, out_valid;
    logic [NS*MW-1:0] out_metrics;

    always #4 clk = ~clk;

    trellis_acs_step #(.MW(MW), .LW(LW)) i_trellis_acs_step (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .start(start), .dir_bwd(dir_bwd), .exact_en(exact_en),
        .llr_sys(llr_sys), .llr_apr(llr_apr), .llr_par(llr_par),
        .in_metrics(in_metrics), .out_valid(out_valid), .out_ready(out_ready),
        .out_metrics(out_metrics)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    logic [NS*MW-1:0] exp_q [$];
    string            tag_q [$];
    logic [NS*MW-1:0] last_exp = '0;
    bit               held_v = 0;
    logic [NS*MW-1:0] held_d;

    int fw_s0 [8] = '{0,3,4,7,1,2,5,6};
    int fw_p0 [8] = '{0,1,1,0,0,1,1,0};
    int fw_s1 [8] = '{1,2,5,6,0,3,4,7};
    int fw_p1 [8] = '{1,0,0,1,1,0,0,1};
    int bw_s0 [8] = '{0,4,5,1,2,6,7,3};
    int bw_p0 [8] = '{0,0,1,1,1,1,0,0};
    int bw_s1 [8] = '{4,0,1,5,6,2,3,7};
    int bw_p1 [8] = '{1,1,0,0,0,0,1,1};

    function automatic int corr(input int d);
        if (d == 0) return 3;
        if (d <= 3) return 2;
        if (d <= 8) return 1;
        return 0;
    endfunction

    function automatic logic [NS*MW-1:0] model(
        input logic [NS*MW-1:0] met, input int sys, input int apr, input int par,
        input bit bwd, input bit ex, input bit st);
        int src [8];
        int nv [8];
        logic [NS*MW-1:0] r;
        for (int s = 0; s < 8; s++)
            src[s] = st ? ((s == 0) ? 0 : -(2 ** (MW-2))) : int'($signed(met[s*MW +: MW]));
        for (int s = 0; s < 8; s++) begin
            int a, b, d, mx;
            a = src[bwd ? bw_s0[s] : fw_s0[s]] + par * (bwd ? bw_p0[s] : fw_p0[s]);
            b = src[bwd ? bw_s1[s] : fw_s1[s]] + (sys + apr) + par * (bwd ? bw_p1[s] : fw_p1[s]);
            d  = (a > b) ? a - b : b - a;
            mx = (a > b) ? a : b;
            nv[s] = mx + (ex ? corr(d) : 0);
        end
        for (int s = 0; s < 8; s++) begin
            int v;
            v = nv[s] - nv[0];
            if (v > 2 ** (MW-1) - 1) v = 2 ** (MW-1) - 1;
            if (v < -(2 ** (MW-1)))  v = -(2 ** (MW-1));
            r[s*MW +: MW] = MW'(v);
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [NS*MW-1:0] act, input logic [NS*MW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle of stimulus, then evaluate it against the model before the edge.
    task automatic cyc(input bit iv, input bit st, input bit bw, input bit ex,
                       input int sys, input int apr, input int par,
                       input logic [NS*MW-1:0] met, input bit ordy, input string tag);
        @(negedge clk);
        in_valid = iv; start = st; dir_bwd = bw; exact_en = ex;
        llr_sys = LW'(sys); llr_apr = LW'(apr); llr_par = LW'(par);
        in_metrics = met; out_ready = ordy;
        #1;
        if (held_v) chk(out_metrics == held_d, "R9 hold", out_metrics, held_d);
        chk(out_valid == (exp_q.size() != 0), "R8 out_valid", {95'd0, out_valid}, {95'd0, exp_q.size() != 0});
        chk(in_ready == (exp_q.size() == 0 || ordy), "R8 in_ready", {95'd0, in_ready}, {95'd0, (exp_q.size() == 0 || ordy)});
        if (out_valid && ordy && exp_q.size() != 0) begin
            logic [NS*MW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(out_metrics == e, t, out_metrics, e);
            chk(out_metrics[MW-1:0] == '0, "R6 state0 zero", out_metrics, e);
        end
        held_v = out_valid && !ordy;
        held_d = out_metrics;
        if (iv && in_ready) begin
            last_exp = model(met, sys, apr, par, bw, ex, st);
            exp_q.push_back(last_exp);
            tag_q.push_back(tag);
        end
    endtask

    function automatic int rs(input int lo, input int hi);
        return lo + int'($urandom_range(0, hi - lo));
    endfunction

    function automatic logic [NS*MW-1:0] rmet(input int amp);
        logic [NS*MW-1:0] r;
        for (int s = 0; s < NS; s++) r[s*MW +: MW] = MW'(rs(-amp, amp));
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(7));
        // R10: reset state
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R10 out_valid", {95'd0, out_valid}, '0);
        chk(in_ready == 1'b1, "R10 in_ready", {95'd0, in_ready}, 96'd1);
        @(negedge clk);
        rst = 1'b0;

        // R8: single step latency then drain
        cyc(1, 1, 0, 0, 5, 2, -3, '0, 1, "R8 data");
        cyc(0, 0, 0, 0, 0, 0, 0, '0, 1, "R8 data");
        cyc(0, 0, 0, 0, 0, 0, 0, '0, 1, "R8 data");

        // R3: forward max-only chain, varied LLRs
        cyc(1, 1, 0, 0, 10, -4, 7, '0, 1, "R3 branch");
        for (int i = 0; i < 60; i++)
            cyc(1, 0, 0, 0, rs(-40, 40), rs(-40, 40), rs(-40, 40), last_exp, 1, "R3 branch");

        // R4: forward exact chain with small LLRs (corrections active)
        cyc(1, 1, 0, 1, 1, 0, -1, '0, 1, "R4 exact");
        for (int i = 0; i < 120; i++)
            cyc(1, 0, 0, 1, rs(-6, 6), rs(-6, 6), rs(-6, 6), last_exp, 1, "R4 exact");
        for (int i = 0; i < 80; i++)
            cyc(1, 0, i % 2 == 1, 1, rs(-5, 5), rs(-5, 5), rs(-5, 5), rmet(10), 1, "R4 exact");

        // R5: max-only, both directions
        for (int i = 0; i < 120; i++)
            cyc(1, 0, i % 2 == 0, 0, rs(-8, 8), rs(-8, 8), rs(-8, 8), rmet(12), 1, "R5 maxonly");

        // R1: forward exact, random metrics
        for (int i = 0; i < 150; i++)
            cyc(1, 0, 0, 1, rs(-30, 30), rs(-30, 30), rs(-30, 30), rmet(300), 1, "R1 forward");

        // R2: backward, chained and random
        cyc(1, 1, 1, 1, 3, 3, -2, '0, 1, "R2 backward");
        for (int i = 0; i < 80; i++)
            cyc(1, 0, 1, 1, rs(-20, 20), rs(-20, 20), rs(-20, 20), last_exp, 1, "R2 backward");
        for (int i = 0; i < 150; i++)
            cyc(1, 0, 1, i % 3 != 0, rs(-30, 30), rs(-30, 30), rs(-30, 30), rmet(300), 1, "R2 backward");

        // R6: extreme values driving saturation
        for (int i = 0; i < 200; i++)
            cyc(1, 0, i % 2 == 1, i % 4 < 2, rs(-128, 127), rs(-128, 127), rs(-128, 127), rmet(2047), 1, "R6 saturate");

        // R7: start ignores arbitrary in_metrics
        for (int i = 0; i < 120; i++)
            cyc(1, 1, i % 2 == 1, i % 4 < 2, rs(-60, 60), rs(-60, 60), rs(-60, 60), rmet(2047), 1, "R7 start");

        // R9: independent valid and ready with all modes mixed
        for (int i = 0; i < 1500; i++) begin
            bit st;
            st = ($urandom_range(0, 9) == 0);
            cyc($urandom_range(0, 3) != 0, st, $urandom_range(0, 1), $urandom_range(0, 1),
                rs(-50, 50), rs(-50, 50), rs(-50, 50),
                ($urandom_range(0, 1) == 1) ? last_exp : rmet(1500),
                $urandom_range(0, 9) < 6, "R9 backpressure");
        end
        for (int i = 0; i < 4; i++)
            cyc(0, 0, 0, 0, 0, 0, 0, '0, 1, "R8 data");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule